// File: doc/BRIEF.md
# Eight-bit ALU with compare flags

This block is the arithmetic and logic unit of a small 8-bit register machine. The decoder sends it an operation byte and two operand values, A and B, and raises `opValid` for one cycle. Most operations finish at the next clock edge. The unit then returns the value to be written back into A's register, together with a one-cycle write enable. The operation byte selects the function directly, so the decoder passes on the byte it fetched without translating it.

A compare writes no register. It only refreshes a three-bit flag register that later conditional jumps read. Divide and modulo run on a bit-serial restoring divider that needs one cycle per result bit, and `busy` is high while it works. A zero divisor does not start the divider. It produces a single-cycle fault strobe, which the surrounding machine uses to halt.

Top module: `alu8_core`

## Requirements
- R1: After reset, `resultValid`, `divFault` and `busy` are 0, and `flags` and `resultData` are 0.
- R2: ADD (0xA0), SUB (0xA1), MUL (0xA2), INC (0x65, A+1) and DEC (0x66, A-1) return the low 8 bits of the exact result, so they wrap modulo 256. `resultValid` is high for exactly the one cycle that follows the edge accepting the operation.
- R3: AND (0xA8), OR (0xAA) and XOR (0xAB) combine A with B bit by bit. NOT (0x69) inverts A. Each returns its result in the cycle after acceptance.
- R4: SHL (0xAC) shifts A left and SHR (0xAD) shifts A right. The unsigned count is taken from B and the vacated bits are filled with zeros. Any count of 8 or more gives 0.
- R5: CMP (0xA7) compares A and B as unsigned numbers and sets `flags` to {A<B, A>B, A==B}, that is bit 2 = less, bit 1 = greater and bit 0 = equal. Exactly one flag is set. `resultValid` stays low.
- R6: No operation except an accepted CMP changes `flags`.
- R7: DIV (0xA3) returns floor(A/B) and MOD (0xA4) returns A mod B. `busy` is high from the accepting edge up to the 8th edge after it. `resultValid` rises at that 8th edge, carrying the result.
- R8: When DIV or MOD is accepted with B = 0, `divFault` is high for exactly the following cycle. No result is written and the divider does not start.
- R9: An operation presented while `busy` is high is ignored. An operation byte outside the list above gives no result, no fault and no flag change, and it leaves `resultData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 8 | Operation byte |
| operandA | input | 8 | First operand, and the destination's current value |
| operandB | input | 8 | Second operand, shift count or divisor |
| busy | output | 1 | The divider is running and new operations are ignored |
| resultValid | output | 1 | Write-enable strobe for `resultData` |
| resultData | output | 8 | Result to be written back to A's register |
| flags | output | 3 | Compare flags {less, greater, equal} |
| divFault | output | 1 | Divide-by-zero halt strobe |

## Verification
If the divider's remainder register or its step counter goes wrong, `resultData` on the DIV/MOD write-back edge is wrong, or `resultValid` arrives one or more cycles away from the 8th edge. Either way the fault shows within one operation. A stuck control state shows up as `busy` failing to drop, which makes the next operation disappear, or as a result strobe after a compare or an unknown opcode. A flag register that is loaded on the wrong operation shows up at `flags` in the cycle after any non-compare operation. The sweeps therefore check flags, strobe and data after every issued operation, not only after the compares.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

  localparam logic [7:0] OP_ADD = 8'hA0;
  localparam logic [7:0] OP_SUB = 8'hA1;
  localparam logic [7:0] OP_MUL = 8'hA2;
  localparam logic [7:0] OP_DIV = 8'hA3;
  localparam logic [7:0] OP_MOD = 8'hA4;
  localparam logic [7:0] OP_CMP = 8'hA7;
  localparam logic [7:0] OP_AND = 8'hA8;
  localparam logic [7:0] OP_OR  = 8'hAA;
  localparam logic [7:0] OP_XOR = 8'hAB;
  localparam logic [7:0] OP_SHL = 8'hAC;
  localparam logic [7:0] OP_SHR = 8'hAD;
  localparam logic [7:0] OP_INC = 8'h65;
  localparam logic [7:0] OP_DEC = 8'h66;
  localparam logic [7:0] OP_NOT = 8'h69;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDiv;    // capture dividend/divisor, clear partial remainder
    logic stepDiv;    // one restoring-division iteration
    logic takeSimple; // register the single-cycle result
    logic takeDiv;    // register the divider's final quotient/remainder
    logic takeFlags;  // register compare flags
    logic pickRem;    // takeDiv selects remainder instead of quotient
  } aluStrobes_t;

  function automatic logic isSimpleOp(input logic [7:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR,
      OP_SHL, OP_SHR, OP_INC, OP_DEC, OP_NOT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu8_ctrl.sv
`timescale 1ns/1ps
module alu8_ctrl
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [7:0]  opCode,
  input  logic        divisorZero,
  output aluStrobes_t strobes,
  output logic        busy,
  output logic        resultValid,
  output logic        divFault
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] STEPS = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(1);

  typedef enum logic {S_IDLE, S_DIVIDING} ctrlState_t;

  ctrlState_t stateR;
  logic [CNT_W-1:0] stepCount;
  logic modLatched;
  logic accept;
  logic isDivOp;
  logic faultNow;

  assign busy    = (stateR == S_DIVIDING);
  assign accept  = opValid && (stateR == S_IDLE);
  assign isDivOp = (opCode == OP_DIV) || (opCode == OP_MOD);

  always_comb begin
    strobes  = '0;
    faultNow = 1'b0;
    if (accept) begin
      strobes.takeSimple = isSimpleOp(opCode);
      strobes.takeFlags  = (opCode == OP_CMP);
      strobes.loadDiv    = isDivOp && !divisorZero;
      faultNow           = isDivOp && divisorZero;
    end
    if (stateR == S_DIVIDING) begin
      strobes.stepDiv = 1'b1;
      strobes.pickRem = modLatched;
      strobes.takeDiv = (stepCount == LAST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR      <= S_IDLE;
      stepCount   <= '0;
      modLatched  <= 1'b0;
      resultValid <= 1'b0;
      divFault    <= 1'b0;
    end else begin
      resultValid <= strobes.takeSimple || strobes.takeDiv;
      divFault    <= faultNow;
      if (strobes.loadDiv) begin
        stateR     <= S_DIVIDING;
        stepCount  <= STEPS;
        modLatched <= (opCode == OP_MOD);
      end else if (stateR == S_DIVIDING) begin
        stepCount <= stepCount - LAST;
        if (stepCount == LAST) stateR <= S_IDLE;
      end
    end
  end

endmodule

// File: rtl/alu8_datapath.sv
`timescale 1ns/1ps
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [7:0]        opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  output logic [DATA_W-1:0] resultData,
  output logic [2:0]        flags
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] simpleRes;
  logic [DATA_W-1:0] remR, quoR, divisorR;
  logic [DATA_W:0]   shifted, trial;
  logic              fits;
  logic [DATA_W-1:0] remNext, quoNext;

  // Single-cycle functions
  always_comb begin
    case (opCode)
      OP_ADD:  simpleRes = operandA + operandB;
      OP_SUB:  simpleRes = operandA - operandB;
      OP_MUL:  simpleRes = operandA * operandB;
      OP_AND:  simpleRes = operandA & operandB;
      OP_OR:   simpleRes = operandA | operandB;
      OP_XOR:  simpleRes = operandA ^ operandB;
      OP_SHL:  simpleRes = operandA << operandB;
      OP_SHR:  simpleRes = operandA >> operandB;
      OP_INC:  simpleRes = operandA + ONE;
      OP_DEC:  simpleRes = operandA - ONE;
      OP_NOT:  simpleRes = ~operandA;
      default: simpleRes = '0;
    endcase
  end

  // One restoring-division step: the dividend bits stream out of quoR's MSB
  always_comb begin
    shifted = {remR, quoR[DATA_W-1]};
    trial   = shifted - {1'b0, divisorR};
    fits    = !trial[DATA_W];
    remNext = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
    quoNext = {quoR[DATA_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR     <= '0;
      quoR     <= '0;
      divisorR <= '0;
    end else if (strobes.loadDiv) begin
      remR     <= '0;
      quoR     <= operandA;
      divisorR <= operandB;
    end else if (strobes.stepDiv) begin
      remR <= remNext;
      quoR <= quoNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData <= '0;
      flags      <= '0;
    end else begin
      if (strobes.takeSimple)   resultData <= simpleRes;
      else if (strobes.takeDiv) resultData <= strobes.pickRem ? remNext : quoNext;
      if (strobes.takeFlags)
        flags <= {operandA < operandB, operandA > operandB, operandA == operandB};
    end
  end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  output logic              busy,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic [2:0]        flags,
  output logic              divFault
);

  aluStrobes_t strobes;
  logic divisorZero;

  assign divisorZero = (operandB == '0);

  alu8_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .divisorZero(divisorZero), .strobes(strobes), .busy(busy),
    .resultValid(resultValid), .divFault(divFault)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opCode(opCode),
    .operandA(operandA), .operandB(operandB),
    .resultData(resultData), .flags(flags)
  );

endmodule

// File: rtl/alu8_checker.sv
`timescale 1ns/1ps
module alu8_checker
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [7:0]        opCode,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB,
  input logic              busy,
  input logic              resultValid,
  input logic [DATA_W-1:0] resultData,
  input logic [2:0]        flags,
  input logic              divFault
);

  logic taken;
  assign taken = opValid && !busy;

  // R2: an accepted ADD writes the wrapped sum in the next cycle
  a_r2_add_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (taken && opCode == OP_ADD) |=>
      (resultValid && resultData == DATA_W'($past(operandA) + $past(operandB))));

  // R5: a compare sets exactly one flag and writes no result
  a_r5_cmp_flags_only: assert property (@(posedge clk) disable iff (!rstN)
    (taken && opCode == OP_CMP) |=> (!resultValid && $countones(flags) == 1));

  // R6: flags move only after an accepted compare
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(taken && opCode == OP_CMP) |=> $stable(flags));

  // R8: a zero divisor faults, writes nothing and leaves the divider idle
  a_r8_zero_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (opCode == OP_DIV || opCode == OP_MOD) && operandB == '0) |=>
      (divFault && !resultValid && !busy));

  // R8: the fault never coincides with a running division
  a_r8_fault_idle: assert property (@(posedge clk) disable iff (!rstN)
    divFault |-> (!busy && !resultValid));

  // R7: busy ends only with the division's write-back
  a_r7_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> resultValid);

endmodule

bind alu8_core alu8_checker #(.DATA_W(DATA_W)) u_alu8_checker (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .operandA(operandA), .operandB(operandB), .busy(busy),
  .resultValid(resultValid), .resultData(resultData),
  .flags(flags), .divFault(divFault)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic [7:0] operandA = 8'h00;
  logic [7:0] operandB = 8'h00;
  logic       busy, resultValid, divFault;
  logic [7:0] resultData;
  logic [2:0] flags;

  int compared = 0;
  int mismatched = 0;
  logic [2:0] expFlags = 3'b000;
  logic [7:0] lastData = 8'h00;

  always #2.5 clk = ~clk;

  alu8_core u_alu8_core (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .operandA(operandA), .operandB(operandB), .busy(busy),
    .resultValid(resultValid), .resultData(resultData),
    .flags(flags), .divFault(divFault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (op=%02h a=%0d b=%0d)",
               tag, act, exp, opCode, operandA, operandB);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge (after the accepting edge)
  task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    opValid = 1'b1; opCode = op; operandA = a; operandB = b;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  function automatic logic [7:0] tv(input int i);
    return (i == 31) ? 8'd255 : 8'(i * 8 + (i % 5));
  endfunction

  function automatic logic [7:0] refSimple(input logic [7:0] op, input logic [7:0] a,
                                           input logic [7:0] b);
    int s;
    case (op)
      8'hA0: s = int'(a) + int'(b);
      8'hA1: s = int'(a) - int'(b) + 256;
      8'hA2: s = int'(a) * int'(b);
      8'h65: s = int'(a) + 1;
      8'h66: s = int'(a) + 255;
      8'hA8: s = int'(a & b);
      8'hAA: s = int'(a | b);
      8'hAB: s = int'(a ^ b);
      8'h69: s = 255 - int'(a);
      8'hAC: s = (b >= 8) ? 0 : int'(a) * (1 << b);
      8'hAD: s = (b >= 8) ? 0 : int'(a) / (1 << b);
      default: s = 0;
    endcase
    return 8'(s % 256);
  endfunction

  function automatic string tagOf(input logic [7:0] op);
    case (op)
      8'hA8, 8'hAA, 8'hAB, 8'h69: return "R3";
      8'hAC, 8'hAD:               return "R4";
      default:                    return "R2";
    endcase
  endfunction

  logic [7:0] simpleOps [11] = '{8'hA0, 8'hA1, 8'hA2, 8'h65, 8'h66, 8'hA8,
                                 8'hAA, 8'hAB, 8'h69, 8'hAC, 8'hAD};

  task automatic runDiv(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] expv;
    expv = (op == 8'hA3) ? 8'(int'(a) / int'(b)) : 8'(int'(a) % int'(b));
    issue(op, a, b);
    chk("R7 busy after accept", 32'(busy), 1);
    chk("R7 no early result", 32'(resultValid), 0);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      if (resultValid) chk("R7 early result", 32'(resultValid), 0);
    end
    @(negedge clk);
    chk("R7 result strobe", 32'(resultValid), 1);
    chk("R7 result value", 32'(resultData), 32'(expv));
    chk("R7 busy released", 32'(busy), 0);
    lastData = expv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 resultValid", 32'(resultValid), 0);
    chk("R1 divFault", 32'(divFault), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 resultData", 32'(resultData), 0);
    rstN = 1'b1;

    // R2, R3, R4, R6: sweep of single-cycle operations
    foreach (simpleOps[n]) begin
      for (int i = 0; i < 32; i++) begin
        for (int j = 0; j < 32; j++) begin
          logic [7:0] bv;
          bv = (simpleOps[n] == 8'hAC || simpleOps[n] == 8'hAD) ? 8'(j % 12 + (j / 12) * 100) : tv(j);
          issue(simpleOps[n], tv(i), bv);
          chk({tagOf(simpleOps[n]), " strobe"}, 32'(resultValid), 1);
          chk({tagOf(simpleOps[n]), " value"}, 32'(resultData),
              32'(refSimple(simpleOps[n], tv(i), bv)));
          chk("R6 flags untouched", 32'(flags), 32'(expFlags));
        end
      end
      // R6: a compare to set known flags between operation groups
      issue(8'hA7, 8'd3, 8'(n));
      expFlags = (3 < n) ? 3'b100 : (3 > n) ? 3'b010 : 3'b001;
      chk("R5 flags", 32'(flags), 32'(expFlags));
    end
    lastData = resultData;

    // R5: compare sweep
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        logic [7:0] a, b;
        a = tv(i); b = (j == i) ? a : tv(j);
        issue(8'hA7, a, b);
        expFlags = {a < b, a > b, a == b};
        chk("R5 no write", 32'(resultValid), 0);
        chk("R5 flags", 32'(flags), 32'(expFlags));
      end
    end

    // R7: divide and modulo sweep
    for (int i = 0; i < 32; i++) begin
      for (int j = 1; j < 32; j++) begin
        runDiv(8'hA3, tv(i), tv(j) == 0 ? 8'd1 : tv(j));
        runDiv(8'hA4, tv(i), tv(j) == 0 ? 8'd1 : tv(j));
      end
    end
    runDiv(8'hA3, 8'd255, 8'd1);
    runDiv(8'hA4, 8'd7, 8'd255);
    chk("R6 flags after divide", 32'(flags), 32'(expFlags));

    // R8: zero divisor
    for (int k = 0; k < 2; k++) begin
      issue(k == 0 ? 8'hA3 : 8'hA4, 8'd77, 8'd0);
      chk("R8 fault strobe", 32'(divFault), 1);
      chk("R8 no result", 32'(resultValid), 0);
      chk("R8 divider idle", 32'(busy), 0);
      @(negedge clk);
      chk("R8 fault is one cycle", 32'(divFault), 0);
      chk("R8 data kept", 32'(resultData), 32'(lastData));
    end

    // R9: operations while busy are ignored
    issue(8'hA3, 8'd200, 8'd7);
    opValid = 1'b1; opCode = 8'hA0; operandA = 8'd1; operandB = 8'd1;
    @(negedge clk);
    chk("R9 add ignored while busy", 32'(resultValid), 0);
    opCode = 8'hA7; operandA = 8'd0; operandB = 8'd9;
    @(negedge clk);
    opValid = 1'b0;
    chk("R9 cmp ignored while busy", 32'(flags), 32'(expFlags));
    repeat (6) @(negedge clk);
    chk("R9 divide completes", 32'(resultValid), 1);
    chk("R9 divide value", 32'(resultData), 28);
    lastData = 8'd28;

    // R9: unknown operation bytes
    foreach (simpleOps[n]) begin
      logic [7:0] bad;
      bad = (n % 2 == 0) ? 8'(8'h82 + n) : 8'(8'hA5 + (n % 2));
      if (bad == 8'h84 || bad == 8'h88) bad = 8'h00;
      issue(bad, 8'd5, 8'd0);
      chk("R9 unknown no result", 32'(resultValid), 0);
      chk("R9 unknown no fault", 32'(divFault), 0);
      chk("R9 unknown flags", 32'(flags), 32'(expFlags));
      chk("R9 unknown data", 32'(resultData), 32'(lastData));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule